// File: doc/BRIEF.md
# Four-Channel Multi-Mode Counter/Timer

This block holds four identical 16-bit counter/timer channels that share one clock. Each channel pairs a running up/down counter with a shadow register, the image. Every bus access goes through the image: a write lands in the image first and reaches the counter on the following clock edge. A read returns the image. While the channel is not capturing, the image follows the counter one cycle behind. The bus therefore never modifies a counter in the middle of a count.

A one-bit global group register selects the behaviour of all channels together. Group 0 is the waveform group: one-shot pulse, square waveform, or watchdog. Group 1 is the capture group: event counting, time capture, or watchdog. Channel 2 is the only channel that can act as a watchdog. In the capture group, watchdog is its only allowed function. Each channel takes its gate or event from one of three sources: a software bit, an external pin, or an internal logic signal. The input polarity and the output polarity are set per channel. A command write that asks for an illegal combination is dropped.

The reset input is asynchronous and active low. It is released through a two-stage synchronizer, so the block leaves reset two clock edges after the input goes high.

Top module: `ctmr_array`

## Requirements
- R1: After reset, all images, all commands and the group bit read 0, every `tmr_out` bit is 0 and `wdog_rst_req` is 0.
- R2: Address map: address 8 is the group register (bit 0 = 1 selects the capture group). For channel u, address 2u is the image and address 2u+1 is the command. A value written to an image reads back from the next cycle on. The counter takes that value on the following edge, and the value also becomes the channel's reload value.
- R3: Command bits [1:0] = 1 in group 0 is the one-shot pulse function. While the gate is active, the counter decrements once per cycle. When it reaches 0, `tmr_out` goes high for exactly one cycle, and the counter then stays at 0. From a loaded value V the pulse appears V cycles after the command write.
- R4: Command bits [1:0] = 2 in group 0 is the waveform function. When the gate is active and the counter is 0, the counter reloads and the output toggles; otherwise the counter decrements. Each output level lasts V+1 cycles.
- R5: Command bits [3:2] pick the gate/event source: 0 is command bit 4 (software), 1 is the channel's `ev_pin` bit, and 2 is its `ev_logic` bit. Command bit 5 inverts the selected input. An inactive gate stops counting.
- R6: Command bit 6 inverts the channel's `tmr_out` bit in every function, including stopped.
- R7: Command bits [1:0] = 1 in group 1 is the event-count function. The counter increments once per rising edge of the selected input, however long the input stays high.
- R8: Command bits [1:0] = 2 in group 1 is the time-capture function. The counter increments every cycle. A rising edge of the selected input copies the counter into the image and sets a capture flag, which reads as bit 7 of the command register. A read of the image clears the flag.
- R9: Command bits [1:0] = 3 on channel 2 is the watchdog function. It counts down like the pulse function and raises `wdog_rst_req` for exactly one cycle when it reaches 0. A command write with bit 7 set reloads the counter from the reload value at that edge.
- R10: A command write is ignored, and the previous command kept, when it asks for source 3, function 3 on any channel other than 2, or function 1 or 2 on channel 2 while the capture group is selected.
- R11: A write to the group register clears every channel's command and capture flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (clears the capture flag on an image read) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ev_pin | input | 4 | External gate/event input, one per channel |
| ev_logic | input | 4 | Internal logic gate/event input, one per channel |
| tmr_out | output | 4 | Channel outputs after polarity |
| wdog_rst_req | output | 1 | One-cycle reset request from the channel 2 watchdog |

## Verification
A wrong count, reload or load-transfer value shows up in the pulse or toggle timing on `tmr_out` or `wdog_rst_req`. It is off by a whole number of cycles and can be seen within one period of the loaded value. Capture and event errors show in the image readback right after the stimulus. A wrong legality decision shows as a command readback differing from the last legal write on the very next read. A flag that fails to clear or to set is visible in bit 7 of the following command read.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    FN_OFF  = 2'd0,
    FN_A    = 2'd1,
    FN_B    = 2'd2,
    FN_WDOG = 2'd3
  } ctmr_fn_e;

  typedef struct packed {
    logic       oinv;
    logic       iinv;
    logic       sw;
    logic [1:0] src;
    ctmr_fn_e   func;
  } ctmr_cmd_t;

  function automatic logic cmd_legal(input ctmr_cmd_t c, input logic is_wd, input logic grp);
    logic ok;
    ok = 1'b1;
    if (c.src == 2'd3) ok = 1'b0;
    if (c.func == FN_WDOG && !is_wd) ok = 1'b0;
    if (is_wd && grp && (c.func == FN_A || c.func == FN_B)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/ctmr_evsel.sv
module ctmr_evsel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw,
  input  logic       pin,
  input  logic       lgc,
  input  logic [1:0] src,
  input  logic       inv,
  output logic       lvl,
  output logic       rise
);
  logic raw;
  logic prev_q, prev_d;

  always_comb begin
    unique case (src)
      2'd0:    raw = sw;
      2'd1:    raw = pin;
      2'd2:    raw = lgc;
      default: raw = 1'b0;
    endcase
    lvl    = raw ^ inv;
    rise   = lvl & ~prev_q;
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/ctmr_unit.sv
module ctmr_unit
  import ctmr_pkg::*;
#(
  parameter int W      = 16,
  parameter bit HAS_WD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         grp,
  input  ctmr_fn_e     func,
  input  logic         oinv,
  input  logic         lvl,
  input  logic         rise,
  input  logic         img_we,
  input  logic [W-1:0] img_wdata,
  input  logic         img_re,
  input  logic         restart,
  output logic [W-1:0] img,
  output logic         flag,
  output logic         out,
  output logic         wd_pulse
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d, img_q, img_d, rel_q, rel_d;
  logic         pend_q, pend_d, tog_q, tog_d, pls_q, pls_d, wdp_q, wdp_d, flag_q, flag_d;
  logic         cap, down_ok;

  always_comb begin
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    tog_d   = tog_q;
    pls_d   = 1'b0;
    wdp_d   = 1'b0;
    cap     = 1'b0;
    down_ok = lvl && (cnt_q != '0);
    if (pend_q) begin
      cnt_d = img_q;
      rel_d = img_q;
    end else if (restart) begin
      cnt_d = rel_q;
    end else begin
      unique case (func)
        FN_A: begin
          if (!grp) begin
            if (down_ok) begin
              cnt_d = cnt_q - ONE;
              pls_d = (cnt_q == ONE);
            end
          end else if (rise) begin
            cnt_d = cnt_q + ONE;
          end
        end
        FN_B: begin
          if (!grp) begin
            if (lvl) begin
              if (cnt_q == '0) begin
                cnt_d = rel_q;
                tog_d = ~tog_q;
              end else begin
                cnt_d = cnt_q - ONE;
              end
            end
          end else begin
            cnt_d = cnt_q + ONE;
            cap   = rise;
          end
        end
        FN_WDOG: begin
          if (HAS_WD && down_ok) begin
            cnt_d = cnt_q - ONE;
            wdp_d = (cnt_q == ONE);
          end
        end
        default: ;
      endcase
    end

    pend_d = 1'b0;
    img_d  = img_q;
    if (img_we) begin
      img_d  = img_wdata;
      pend_d = 1'b1;
    end else if (!pend_q) begin
      if (grp && func == FN_B) begin
        if (cap) img_d = cnt_q;
      end else begin
        img_d = cnt_q;
      end
    end

    flag_d = flag_q;
    if (clr)         flag_d = 1'b0;
    else if (cap)    flag_d = 1'b1;
    else if (img_re) flag_d = 1'b0;
    if (clr) tog_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      img_q  <= '0;
      rel_q  <= '0;
      pend_q <= 1'b0;
      tog_q  <= 1'b0;
      pls_q  <= 1'b0;
      wdp_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      img_q  <= img_d;
      rel_q  <= rel_d;
      pend_q <= pend_d;
      tog_q  <= tog_d;
      pls_q  <= pls_d;
      wdp_q  <= wdp_d;
      flag_q <= flag_d;
    end
  end

  assign img      = img_q;
  assign flag     = flag_q;
  assign wd_pulse = wdp_q;
  assign out      = oinv ^ (!grp && ((func == FN_B) ? tog_q : (func == FN_A) ? pls_q : 1'b0));

  // R2
  img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_we |=> (pend_q && img_q == $past(img_wdata)));
  // R2
  load_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (cnt_q == $past(img_q)));
  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !img_we && !clr) |=> (img_q == $past(cnt_q) && flag_q));
  // R3
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q |-> (cnt_q == '0));
  // R9
  wd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdp_q |=> !wdp_q);
endmodule

// File: rtl/ctmr_array.sv
module ctmr_array
  import ctmr_pkg::*;
#(
  parameter int N      = 4,
  parameter int W      = 16,
  parameter int WD_IDX = 2,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [N-1:0]  ev_pin,
  input  logic [N-1:0]  ev_logic,
  output logic [N-1:0]  tmr_out,
  output logic          wdog_rst_req
);
  localparam int UW = (N > 1) ? $clog2(N) : 1;

  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic          gmode_q, gmode_d, gm_we;
  logic [UW-1:0] u_sel;
  ctmr_cmd_t     wcmd;
  ctmr_cmd_t     cmd_q [N];
  logic [W-1:0]  img_w [N];
  logic [N-1:0]  flag_w, wd_w;

  assign gm_we   = bus_we && bus_addr[AW-1];
  assign u_sel   = bus_addr[UW:1];
  assign wcmd    = ctmr_cmd_t'(bus_wdata[6:0]);
  assign gmode_d = gm_we ? bus_wdata[0] : gmode_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) gmode_q <= 1'b0;
    else         gmode_q <= gmode_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic      hit, cmd_we, img_we, img_re, legal, restart, lvl, rise;
    ctmr_cmd_t cmd_d;

    assign hit     = !bus_addr[AW-1] && (u_sel == UW'(i));
    assign cmd_we  = bus_we && hit && bus_addr[0];
    assign img_we  = bus_we && hit && !bus_addr[0];
    assign img_re  = bus_re && hit && !bus_addr[0];
    assign legal   = cmd_legal(wcmd, i == WD_IDX, gmode_q);
    assign restart = cmd_we && legal && bus_wdata[7] && (wcmd.func == FN_WDOG);

    always_comb begin
      cmd_d = cmd_q[i];
      if (gm_we)                cmd_d = '0;
      else if (cmd_we && legal) cmd_d = wcmd;
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) cmd_q[i] <= '0;
      else         cmd_q[i] <= cmd_d;
    end

    ctmr_evsel u_evsel (
      .clk  (clk),
      .rst_n(rst_ns),
      .sw   (cmd_q[i].sw),
      .pin  (ev_pin[i]),
      .lgc  (ev_logic[i]),
      .src  (cmd_q[i].src),
      .inv  (cmd_q[i].iinv),
      .lvl  (lvl),
      .rise (rise)
    );

    ctmr_unit #(.W(W), .HAS_WD(i == WD_IDX)) u_unit (
      .clk      (clk),
      .rst_n    (rst_ns),
      .clr      (gm_we),
      .grp      (gmode_q),
      .func     (cmd_q[i].func),
      .oinv     (cmd_q[i].oinv),
      .lvl      (lvl),
      .rise     (rise),
      .img_we   (img_we),
      .img_wdata(bus_wdata),
      .img_re   (img_re),
      .restart  (restart),
      .img      (img_w[i]),
      .flag     (flag_w[i]),
      .out      (tmr_out[i]),
      .wd_pulse (wd_w[i])
    );

    // R10
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (cmd_we && !legal) |=> $stable(cmd_q[i]));
    // R11
    group_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      gm_we |=> (cmd_q[i] == '0 && !flag_w[i]));
  end

  assign wdog_rst_req = wd_w[WD_IDX];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW-1]) begin
      bus_rdata[0] = gmode_q;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (u_sel == UW'(i)) begin
          if (bus_addr[0]) bus_rdata[7:0] = {flag_w[i], cmd_q[i]};
          else             bus_rdata    = img_w[i];
        end
      end
    end
  end
endmodule

// File: tb/ctmr_array_bench.sv
`timescale 1ns/1ps
module ctmr_array_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we, bus_re;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  ev_pin, ev_logic, tmr_out;
  logic        wdog_rst_req;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;
  logic [6:0] mdl [4];

  always #2.5 clk = ~clk;

  ctmr_array u_ctmr_array (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pin(ev_pin), .ev_logic(ev_logic), .tmr_out(tmr_out),
    .wdog_rst_req(wdog_rst_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 4'(a); bus_wdata = 16'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 4'(a); bus_re = 1'b1;
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic sig(input int idx);
    return (idx < 4) ? tmr_out[idx] : wdog_rst_req;
  endfunction

  task automatic wait_lvl(input int idx, input logic lv, output int cyc);
    cyc = 0;
    while (sig(idx) !== lv && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic bit exp_legal(input int u, input bit gm, input logic [7:0] c);
    if (c[3:2] == 2'd3) return 0;
    if (c[1:0] == 2'd3 && u != 2) return 0;
    if (gm && u == 2 && (c[1:0] == 2'd1 || c[1:0] == 2'd2)) return 0;
    return 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int d, cyc, seed, u, v, k;
    logic [7:0] c;
    seed = int'($urandom(32'h5eed));
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    ev_pin = 0; ev_logic = 0;
    foreach (mdl[i]) mdl[i] = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(a, d); chk("R1 reg", d, 0);
    end
    chk("R1 tmr_out", int'(tmr_out), 0);
    chk("R1 wdog", int'(wdog_rst_req), 0);

    // R6 output polarity with the channel stopped
    wr(7, 8'h40); chk("R6 inverted", int'(tmr_out[3]), 1);
    wr(7, 8'h00); chk("R6 plain", int'(tmr_out[3]), 0);

    // R2 image round trip, random values
    for (int n = 0; n < 8; n++) begin
      u = int'($urandom % 4); v = int'($urandom & 16'hffff);
      wr(2*u, v);
      rd(2*u, d); chk("R2 image readback", d, v);
      rd(2*u, d); chk("R2 image after transfer", d, v);
    end

    // R3 one-shot pulse
    for (int n = 0; n < 3; n++) begin
      u = int'($urandom % 4); v = 1 + int'($urandom % 30);
      wr(2*u, v); wr(2*u+1, 8'h11);
      wait_lvl(u, 1'b1, cyc); chk("R3 pulse delay", cyc, v);
      @(negedge clk); chk("R3 pulse width", int'(tmr_out[u]), 0);
      rd(2*u, d); chk("R3 holds zero", d, 0);
      wr(2*u+1, 8'h00);
    end

    // R4 waveform
    v = 2 + int'($urandom % 19);
    wr(2, v); wr(3, 8'h12);
    wait_lvl(1, 1'b1, cyc); chk("R4 first toggle", cyc, v+1);
    wait_lvl(1, 1'b0, cyc); chk("R4 high time", cyc, v+1);
    wait_lvl(1, 1'b1, cyc); chk("R4 low time", cyc, v+1);
    wr(3, 8'h00);

    // R5 gate sources and input polarity
    ev_pin[0] = 1'b1;
    wr(0, 6); wr(1, 8'h05);
    wait_lvl(0, 1'b1, cyc); chk("R5 pin gate", cyc, 6);
    ev_logic[1] = 1'b0;
    wr(2, 7); wr(3, 8'h29);
    wait_lvl(1, 1'b1, cyc); chk("R5 inverted logic gate", cyc, 7);
    wr(4, 9); wr(5, 8'h01);
    repeat (12) @(negedge clk);
    chk("R5 sw gate off output", int'(tmr_out[2]), 0);
    rd(4, d); chk("R5 sw gate off count", d, 9);
    mdl[0] = 7'h05; mdl[1] = 7'h29; mdl[2] = 7'h01; mdl[3] = 7'h00;

    // R9 watchdog with restart
    v = 3 + int'($urandom % 28);
    wr(4, v); wr(5, 8'h13); mdl[2] = 7'h13;
    wait_lvl(4, 1'b1, cyc); chk("R9 watchdog delay", cyc, v);
    @(negedge clk); chk("R9 pulse width", int'(wdog_rst_req), 0);
    wr(5, 8'h93);
    repeat (2) @(negedge clk);
    wr(5, 8'h93);
    wait_lvl(4, 1'b1, cyc); chk("R9 restart reload", cyc, v);

    // R10 directed illegal writes
    wr(1, 8'h03); rd(1, d); chk("R10 func3 off channel 2", d, int'(mdl[0]));
    wr(3, 8'h1C); rd(3, d); chk("R10 source 3", d, int'(mdl[1]));

    // R10 random commands in group 0
    for (int n = 0; n < 40; n++) begin
      u = int'($urandom % 4); c = 8'($urandom) & 8'h7f;
      wr(2*u+1, c);
      if (exp_legal(u, 1'b0, c)) mdl[u] = c[6:0];
      rd(2*u+1, d); chk("R10 random command", d, int'(mdl[u]));
    end

    // R11 group write clears commands
    wr(8, 1);
    for (int i = 0; i < 4; i++) begin
      rd(2*i+1, d); chk("R11 command cleared", d, 0);
    end
    rd(8, d); chk("R11 group bit", d, 1);

    // R10 channel 2 in the capture group
    wr(5, 8'h01); rd(5, d); chk("R10 ch2 event in capture group", d, 0);
    wr(5, 8'h02); rd(5, d); chk("R10 ch2 capture in capture group", d, 0);
    wr(5, 8'h13); rd(5, d); chk("R10 ch2 watchdog in capture group", d, 8'h13);
    wr(5, 8'h00);

    // R7 event count
    k = 3 + int'($urandom % 8);
    wr(2, 0); wr(3, 8'h05);
    for (int n = 0; n < k; n++) begin
      ev_pin[1] = 1'b1; @(negedge clk);
      if (n == 0) begin ev_pin[1] = 1'b1; @(negedge clk); end
      ev_pin[1] = 1'b0; @(negedge clk);
    end
    rd(2, d); chk("R7 event count", d, k);

    // R8 time capture
    for (int n = 0; n < 2; n++) begin
      k = 5 + int'($urandom % 36);
      wr(0, 0); wr(1, 8'h0A);
      repeat (k) @(negedge clk);
      ev_logic[0] = 1'b1; @(negedge clk); ev_logic[0] = 1'b0;
      rd(1, d); chk("R8 flag set", d, 8'h8A);
      rd(0, d); chk("R8 captured value", d, k);
      rd(1, d); chk("R8 flag cleared", d, 8'h0A);
      rd(0, d); chk("R8 image holds", d, k);
      wr(1, 8'h00);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule